// File: doc/BRIEF.md
# Limp-Home Clock Recovery Supervisor

This block supervises the system clock selection of a microcontroller around the low-power stop state. It takes stop and wake requests from the core and decides how the part comes out of stop. With the wake delay bit set, it holds stop for a full count period of the slow tick. With the delay bit clear, it recovers fast. For a square-wave clock source it runs at once. For a crystal it falls back to an internal limp-home clock while the crystal settles.

In limp-home mode the clock monitor enables are forced on and the PLL and clock-select outputs are parked. A counter driven by the tick enable probes the clock-present indication once per counter period. When an external clock is seen, the block leaves limp-home mode and raises a sticky interrupt flag. It then restores the bus and mode clock selection saved when the clock was lost. The PLL enable returns only when the auto bit and the restored PLL selection allow it. Software may rewrite the saved selection while in limp-home mode, for example to keep the PLL off after recovery.

Top module: `lhclk_supervisor`

## Requirements
- R1: After reset, lh_status, stop_active, lh_irq_flag, irq, bcsp_out, mcs_out and pll_en are all 0.
- R2: Outside limp-home mode and outside stop, a cfg_wr pulse loads cfg_bcsp and cfg_mcs, and they show on bcsp_out and mcs_out in the following cycle. While running, pll_en equals bcsp_out AND cfg_auto.
- R3: A stop_req while running raises stop_active in the next cycle. While stop_active is 1 and cfg_no_lhm is 0, cme_eff and fcme_eff are 0. With cfg_no_lhm at 1, they follow cfg_cme and cfg_fcme.
- R4: A wake_req in stop with cfg_dly 0 and ext_square 1 drops stop_active in the next cycle, and lh_status stays 0.
- R5: A wake_req in stop with cfg_dly 0, ext_square 0 and cfg_no_lhm 0 drops stop_active and raises lh_status in the next cycle. While lh_status is 1, cme_eff and fcme_eff are 1 and bcsp_out, mcs_out and pll_en are 0.
- R6: In limp-home mode a CNT_W-bit counter starts at 0 on entry and advances once per tick. The probe fires on the ticks numbered 2^(CNT_W-1) + k*2^CNT_W after entry, for k = 0, 1, 2 and so on. If clk_present is 1 on a probe tick, lh_status is 0 in the next cycle. Otherwise limp-home mode continues.
- R7: Leaving limp-home mode sets lh_irq_flag in the same cycle that lh_status clears. A same-cycle irq_clr does not prevent this.
- R8: On leaving limp-home mode, bcsp_out and mcs_out return to the selection held when limp-home mode was entered. pll_en returns to 1 when that bcsp value and cfg_auto are both 1.
- R9: A cfg_wr pulse during limp-home mode replaces the saved selection. Writing cfg_bcsp 0 keeps pll_en at 0 after recovery.
- R10: A wake_req in stop with cfg_dly 1 keeps stop_active at 1 until 2^CNT_W ticks have been counted. stop_active is 0 in the cycle after the last of those ticks, and lh_status stays 0.
- R11: lh_irq_flag stays set until an irq_clr pulse clears it. irq equals lh_irq_flag AND irq_en.
- R12: stop_req has no effect in limp-home mode: stop_active stays 0 and lh_status stays 1.
- R13: A wake_req in stop with cfg_dly 0, ext_square 0 and cfg_no_lhm 1 returns to run without limp-home mode: stop_active and lh_status are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow tick enable, one cycle per tick |
| stop_req | input | 1 | Request to enter stop |
| wake_req | input | 1 | Request to leave stop |
| cfg_wr | input | 1 | Write strobe for the clock-selection bits |
| cfg_no_lhm | input | 1 | Disable limp-home fallback |
| cfg_cme | input | 1 | Clock-monitor enable |
| cfg_fcme | input | 1 | Forced clock-monitor enable |
| cfg_dly | input | 1 | Wait a full count period on stop exit |
| cfg_auto | input | 1 | Automatic PLL engagement |
| cfg_bcsp | input | 1 | Bus clock from PLL selection |
| cfg_mcs | input | 1 | Mode clock selection |
| clk_present | input | 1 | Clock monitor sees an external clock |
| ext_square | input | 1 | External source is a square wave, not a crystal |
| irq_en | input | 1 | Interrupt enable for the recovery flag |
| irq_clr | input | 1 | Write-one-to-clear pulse for the recovery flag |
| lh_status | output | 1 | Limp-home mode active |
| lh_irq_flag | output | 1 | Sticky recovery interrupt flag |
| irq | output | 1 | Interrupt request |
| cme_eff | output | 1 | Effective clock-monitor enable |
| fcme_eff | output | 1 | Effective forced clock-monitor enable |
| stop_active | output | 1 | Stop state in force |
| bcsp_out | output | 1 | Active bus-clock PLL selection |
| mcs_out | output | 1 | Active mode clock selection |
| pll_en | output | 1 | PLL enable |

## Verification
Two events can fall in the same cycle. A successful probe sets the recovery flag while software's clear pulse tries to drop it. A selection write in limp-home mode can also land on the tick that ends it. The bench pulses irq_clr exactly on the probe tick and expects the flag to read 1 afterwards. It also sweeps the cycle at which the clock returns across three probe periods. For each start point it computes the exit tick from the counter period, then checks the restored selection and PLL enable against the values written before the loss.

// File: rtl/lhs_pkg.sv
package lhs_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_STOP = 2'd1,
      ST_WAIT = 2'd2,
      ST_LIMP = 2'd3
   } lhs_state_e;

   typedef struct packed {
      logic bcsp;
      logic mcs;
   } clk_sel_t;
endpackage

// File: rtl/lhs_tick_counter.sv
module lhs_tick_counter #(
   parameter int CNT_W = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic probe,
   output logic wrap
);
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'((1 << (CNT_W-1)) - 1);
   localparam logic [CNT_W-1:0] ALL_ONE = '1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (tick)   cnt_q <= cnt_q + 1'b1;
   end

   assign probe = tick && !clr && (cnt_q == HALF_M1);
   assign wrap  = tick && !clr && (cnt_q == ALL_ONE);
endmodule

// File: rtl/lhs_sel_store.sv
module lhs_sel_store
   import lhs_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr,
   input  clk_sel_t wr_val,
   input  logic     in_limp,
   input  logic     enter_limp,
   input  logic     leave_limp,
   output clk_sel_t act
);
   clk_sel_t act_q, saved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         saved_q <= '0;
      end else if (enter_limp) begin
         saved_q <= wr ? wr_val : act_q;
      end else if (leave_limp) begin
         act_q   <= wr ? wr_val : saved_q;
      end else if (in_limp) begin
         if (wr) saved_q <= wr_val;
      end else if (wr) begin
         act_q <= wr_val;
      end
   end

   assign act = act_q;
endmodule

// File: rtl/lhs_irq_flag.sv
module lhs_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (set)  flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/lhclk_supervisor.sv
module lhclk_supervisor
   import lhs_pkg::*;
#(
   parameter int CNT_W = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic stop_req,
   input  logic wake_req,
   input  logic cfg_wr,
   input  logic cfg_no_lhm,
   input  logic cfg_cme,
   input  logic cfg_fcme,
   input  logic cfg_dly,
   input  logic cfg_auto,
   input  logic cfg_bcsp,
   input  logic cfg_mcs,
   input  logic clk_present,
   input  logic ext_square,
   input  logic irq_en,
   input  logic irq_clr,
   output logic lh_status,
   output logic lh_irq_flag,
   output logic irq,
   output logic cme_eff,
   output logic fcme_eff,
   output logic stop_active,
   output logic bcsp_out,
   output logic mcs_out,
   output logic pll_en
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("lhclk_supervisor: CNT_W must be at least 2");
      end
   endgenerate

   lhs_state_e state_q, state_d;
   logic       probe, wrap, cnt_clr;
   logic       enter_limp, leave_limp, in_limp;
   clk_sel_t   act_sel, wr_sel;

   assign in_limp    = (state_q == ST_LIMP);
   assign enter_limp = (state_q == ST_STOP) && wake_req && !cfg_dly &&
                       !ext_square && !cfg_no_lhm;
   assign leave_limp = in_limp && probe && clk_present;
   assign cnt_clr    = (state_q == ST_RUN) || (state_q == ST_STOP);
   assign wr_sel     = '{bcsp: cfg_bcsp, mcs: cfg_mcs};

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:  if (stop_req) state_d = ST_STOP;
         ST_STOP: begin
            if (wake_req) begin
               if (cfg_dly)         state_d = ST_WAIT;
               else if (enter_limp) state_d = ST_LIMP;
               else                 state_d = ST_RUN;
            end
         end
         ST_WAIT: if (wrap) state_d = ST_RUN;
         ST_LIMP: if (leave_limp) state_d = ST_RUN;
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   lhs_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .tick  (tick),
      .probe (probe),
      .wrap  (wrap)
   );

   lhs_sel_store u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (cfg_wr),
      .wr_val     (wr_sel),
      .in_limp    (in_limp),
      .enter_limp (enter_limp),
      .leave_limp (leave_limp),
      .act        (act_sel)
   );

   lhs_irq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (leave_limp),
      .clr   (irq_clr),
      .flag  (lh_irq_flag)
   );

   assign lh_status   = in_limp;
   assign stop_active = (state_q == ST_STOP) || (state_q == ST_WAIT);
   assign irq         = lh_irq_flag && irq_en;

   always_comb begin
      if (in_limp) begin
         cme_eff  = 1'b1;
         fcme_eff = 1'b1;
      end else if (stop_active && !cfg_no_lhm) begin
         cme_eff  = 1'b0;
         fcme_eff = 1'b0;
      end else begin
         cme_eff  = cfg_cme;
         fcme_eff = cfg_fcme;
      end
   end

   assign bcsp_out = in_limp ? 1'b0 : act_sel.bcsp;
   assign mcs_out  = in_limp ? 1'b0 : act_sel.mcs;
   assign pll_en   = (state_q == ST_RUN) && act_sel.bcsp && cfg_auto;
endmodule

// File: rtl/lhclk_supervisor_chk.sv
module lhclk_supervisor_chk #(
   parameter int CNT_W = 13
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic stop_req,
   input logic wake_req,
   input logic cfg_no_lhm,
   input logic cfg_dly,
   input logic ext_square,
   input logic irq_clr,
   input logic lh_status,
   input logic lh_irq_flag,
   input logic cme_eff,
   input logic fcme_eff,
   input logic stop_active,
   input logic pll_en
);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(1 << (CNT_W-1));

   logic [CNT_W-1:0] limp_ticks;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          limp_ticks <= '0;
      else if (!lh_status) limp_ticks <= '0;
      else if (tick)       limp_ticks <= limp_ticks + 1'b1;
   end

   assert_stop_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && !cfg_no_lhm) |-> (!cme_eff && !fcme_eff));

   assert_limp_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lh_status |-> (cme_eff && fcme_eff && !pll_en && !stop_active));

   assert_square_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_active && wake_req && !cfg_dly && ext_square && !lh_status)
      |=> (!stop_active && !lh_status));

   assert_probe_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lh_status) |-> (limp_ticks == HALF));

   assert_flag_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lh_status) |-> lh_irq_flag);

   assert_flag_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lh_irq_flag) |-> $fell(lh_status));

   assert_stop_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (lh_status && stop_req) |=> !stop_active);

   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (lh_irq_flag && !irq_clr) |=> lh_irq_flag);
endmodule

bind lhclk_supervisor lhclk_supervisor_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .stop_req    (stop_req),
   .wake_req    (wake_req),
   .cfg_no_lhm  (cfg_no_lhm),
   .cfg_dly     (cfg_dly),
   .ext_square  (ext_square),
   .irq_clr     (irq_clr),
   .lh_status   (lh_status),
   .lh_irq_flag (lh_irq_flag),
   .cme_eff     (cme_eff),
   .fcme_eff    (fcme_eff),
   .stop_active (stop_active),
   .pll_en      (pll_en)
);

// File: tb/tb_lhclk_supervisor.sv
module tb_lhclk_supervisor;
   localparam int W      = 4;
   localparam int HALF   = 1 << (W-1);
   localparam int PERIOD = 1 << W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 0, stop_req = 0, wake_req = 0, cfg_wr = 0;
   logic cfg_no_lhm = 0, cfg_cme = 1, cfg_fcme = 1, cfg_dly = 0;
   logic cfg_auto = 0, cfg_bcsp = 0, cfg_mcs = 0;
   logic clk_present = 0, ext_square = 0, irq_en = 0, irq_clr = 0;
   logic lh_status, lh_irq_flag, irq, cme_eff, fcme_eff, stop_active;
   logic bcsp_out, mcs_out, pll_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #5 clk = ~clk;

   lhclk_supervisor #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .stop_req(stop_req),
      .wake_req(wake_req), .cfg_wr(cfg_wr), .cfg_no_lhm(cfg_no_lhm),
      .cfg_cme(cfg_cme), .cfg_fcme(cfg_fcme), .cfg_dly(cfg_dly),
      .cfg_auto(cfg_auto), .cfg_bcsp(cfg_bcsp), .cfg_mcs(cfg_mcs),
      .clk_present(clk_present), .ext_square(ext_square), .irq_en(irq_en),
      .irq_clr(irq_clr), .lh_status(lh_status), .lh_irq_flag(lh_irq_flag),
      .irq(irq), .cme_eff(cme_eff), .fcme_eff(fcme_eff),
      .stop_active(stop_active), .bcsp_out(bcsp_out), .mcs_out(mcs_out),
      .pll_en(pll_en)
   );

   task automatic chk(input string req, input string what,
                      input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic chk_int(input string req, input string what,
                          input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write_sel(input logic b, input logic m);
      cfg_bcsp = b; cfg_mcs = m; cfg_wr = 1;
      step();
      cfg_wr = 0;
   endtask

   task automatic do_stop();
      stop_req = 1; step(); stop_req = 0;
   endtask

   task automatic do_wake();
      wake_req = 1; step(); wake_req = 0;
   endtask

   task automatic one_tick();
      tick = 1; step(); tick = 0; step();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      int exit_at;
      logic eb, em;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "lh_status", lh_status, 0);
      chk("R1", "stop_active", stop_active, 0);
      chk("R1", "flag", lh_irq_flag, 0);
      chk("R1", "irq", irq, 0);
      chk("R1", "bcsp_out", bcsp_out, 0);
      chk("R1", "mcs_out", mcs_out, 0);
      chk("R1", "pll_en", pll_en, 0);

      // R2 selection write and PLL enable in run
      for (int i = 0; i < 8; i++) begin
         cfg_auto = i[2];
         write_sel(i[0], i[1]);
         chk("R2", "bcsp_out", bcsp_out, i[0]);
         chk("R2", "mcs_out", mcs_out, i[1]);
         chk("R2", "pll_en", pll_en, i[0] & i[2]);
      end

      // R3 mask during stop, R4 square fast wake
      for (int i = 0; i < 4; i++) begin
         cfg_no_lhm = i[0]; cfg_cme = 1; cfg_fcme = i[1];
         do_stop();
         chk("R3", "stop_active", stop_active, 1);
         chk("R3", "cme_eff", cme_eff, i[0]);
         chk("R3", "fcme_eff", fcme_eff, i[0] & i[1]);
         ext_square = 1; cfg_dly = 0;
         do_wake();
         chk("R4", "stop_active", stop_active, 0);
         chk("R4", "lh_status", lh_status, 0);
         ext_square = 0;
      end
      cfg_no_lhm = 0; cfg_fcme = 1;

      // R13 no-limp-home crystal fast wake
      cfg_no_lhm = 1;
      do_stop();
      do_wake();
      chk("R13", "stop_active", stop_active, 0);
      chk("R13", "lh_status", lh_status, 0);
      cfg_no_lhm = 0;

      // R6 R7 R8 R9 sweep of clock return tick
      for (int p = 1; p <= 3*PERIOD; p++) begin
         cfg_auto = p[1];
         write_sel(p[0], p[2]);
         eb = p[0]; em = p[2];
         irq_clr = 1; step(); irq_clr = 0;
         do_stop();
         do_wake();
         chk("R5", "lh_status", lh_status, 1);
         chk("R5", "stop_active", stop_active, 0);
         chk("R5", "cme_eff", cme_eff & fcme_eff, 1);
         chk("R5", "sel/pll parked", bcsp_out | mcs_out | pll_en, 0);
         if (p == 5) begin
            stop_req = 1; step(); stop_req = 0;
            chk("R12", "stop_active", stop_active, 0);
            chk("R12", "lh_status", lh_status, 1);
         end
         if (p % 7 == 3) begin
            write_sel(1'b0, ~p[2]);   // R9 rewrite saved selection
            eb = 0; em = ~p[2];
         end
         exit_at = 0;
         for (int t = 1; t <= 4*PERIOD && exit_at == 0; t++) begin
            clk_present = (t >= p);
            tick = 1;
            if (p == 2*PERIOD) irq_clr = 1;
            step();
            tick = 0; irq_clr = 0;
            if (!lh_status) exit_at = t;
            step();
         end
         clk_present = 0;
         chk_int("R6", $sformatf("exit tick p=%0d", p), exit_at,
                 (p <= HALF) ? HALF : HALF + PERIOD*((p - HALF + PERIOD - 1)/PERIOD));
         chk("R7", "flag", lh_irq_flag, 1);
         chk((p % 7 == 3) ? "R9" : "R8", "bcsp_out", bcsp_out, eb);
         chk((p % 7 == 3) ? "R9" : "R8", "mcs_out", mcs_out, em);
         chk((p % 7 == 3) ? "R9" : "R8", "pll_en", pll_en, eb & cfg_auto);
      end

      // R11 irq gating and clear
      irq_en = 0; step();
      chk("R11", "irq masked", irq, 0);
      irq_en = 1; step();
      chk("R11", "irq enabled", irq, 1);
      repeat (3) step();
      chk("R11", "flag sticky", lh_irq_flag, 1);
      irq_clr = 1; step(); irq_clr = 0;
      chk("R11", "flag cleared", lh_irq_flag, 0);
      chk("R11", "irq cleared", irq, 0);

      // R10 delayed wake
      cfg_dly = 1;
      do_stop();
      do_wake();
      for (int t = 1; t <= PERIOD; t++) begin
         clk_present = 1;
         tick = 1; step(); tick = 0;
         if (t < PERIOD) chk("R10", $sformatf("stop held t=%0d", t), stop_active, 1);
         else            chk("R10", "stop released", stop_active, 0);
         chk("R10", "no limp", lh_status, 0);
         step();
      end
      cfg_dly = 0;

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule